// File: doc/BRIEF.md
# Frame-Synchronized Serial Port with Programmable Data Delay

This block moves fixed-length words over a single-bit serial line. Each word is framed by a frame-sync pulse, and a programmable gap of zero, one or two bit periods separates that pulse from the first data bit. The serial clock and the frame sync are inputs, and the block runs entirely on the serial clock. The transmitter updates its output on rising edges. The receiver samples the line on falling edges.

On the transmit side, a parallel word is accepted through a valid/ready handshake into a holding stage. When a frame starts, the word is shifted out most significant bit first. With zero delay, the most significant bit leaves the holding stage combinationally during the frame-sync period itself. The transmit pin is enabled only while data bits are on it, so several ports can share one line.

On the receive side, the line is sampled and the word is assembled most significant bit first. Each completed word is presented with a valid flag that stays up until the word is taken. Missed transmit words and lost receive words each set a sticky flag.

Top module: `fsync_serial_port`

## Requirements
- R1: Frame sync is high for one bit period (period 0) and is recognised at the rising edge that ends it. The first data bit occupies period d, where d is the delay setting. Setting values 0, 1 and 2 give d = 0, 1 and 2, and value 3 acts as 2.
- R2: Transmit bits appear on `txOut` most significant bit first, one per period, and change only at rising clock edges. The one exception is the zero-delay first bit (R3).
- R3: With zero delay, the most significant bit of the held word is on `txOut`, with `txOe` high, within period 0 itself. This happens before any rising edge has seen frame sync.
- R4: The receiver samples `rxIn` on falling edges and assembles the word most significant bit first. It raises `rxValid` with the word on `rxData` at the rising edge that follows the last data bit. With zero delay, the first bit is the one sampled in period 0.
- R5: With two-bit delay, the line value in period 1 (a framing bit) is skipped and never enters the received word.
- R6: `txOe` is high in exactly the W data periods of a frame. `txOut` is 0 whenever `txOe` is low.
- R7: `txReady` is high while the holding stage is empty. A word is taken on a rising edge with `txValid` and `txReady` both high. `txReady` then stays low until a frame start consumes the word.
- R8: A frame that starts with no word held transmits all zeros in its data periods and sets `underrun`. The flag stays set until reset.
- R9: `rxValid` stays high until a rising edge with `rxReady` high, and is low after it.
- R10: A word that completes while `rxValid` is high and not being taken replaces `rxData` and sets `overrun`. The flag stays set until reset.
- R11: The delay setting is captured at frame start. Changing it during a frame has no effect on that frame.
- R12: After reset, `txOe` is low, `txReady` is high, and `rxValid`, `underrun` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fsIn | input | 1 | Frame sync, high for one bit period |
| cfgDelay | input | 2 | Data delay select: 0, 1, 2 (3 acts as 2) |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Holding stage empty |
| txWord | input | W | Transmit word |
| txOut | output | 1 | Serial transmit data |
| txOe | output | 1 | Transmit pin drive enable |
| rxIn | input | 1 | Serial receive data |
| rxData | output | W | Last received word |
| rxValid | output | 1 | Received word pending |
| rxReady | input | 1 | Consumer takes the received word |
| underrun | output | 1 | Sticky: frame started with no word held |
| overrun | output | 1 | Sticky: received word overwritten |

## Verification
The hardest situation to reach is the zero-delay first period. In that period, `txOut` and `txOe` must respond combinationally to frame sync while the receiver samples the same bit half a period later. The bench loops the transmit pin back to the receive pin, with the line held high whenever the pin is not driven. It raises frame sync just after a rising edge and probes the pin at every falling edge, so the bit in period 0 is seen directly. The same probe shows that framing-bit ones are skipped under two-bit delay. Changing the delay setting right after each frame starts exercises the capture rule. Withholding a transmit word, and leaving a received word untaken across two frames, drive the two sticky flags.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic holdWrite;   // capture txWord into the holding stage
    logic txLoad;      // frame start: fill the transmit shifter
    logic txLoadSkip;  // zero delay: first bit already sent, preload shifted
    logic txLoadZero;  // underrun: fill with zeros
    logic txShift;     // advance transmit shifter
    logic lead;        // zero-delay period 0: drive from holding stage
    logic leadFull;    // holding stage has a word
    logic rxShift;     // shift the sampled bit into the receive shifter
    logic rxFinish;    // last bit: publish the word
  } fspStrobes_t;

  function automatic logic [1:0] effDelay(input logic [1:0] sel);
    return (sel == 2'd3) ? 2'd2 : sel;
  endfunction

endpackage

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fsIn,
  input  logic        fsNeg,
  input  logic [1:0]  cfgDelay,
  input  logic        txValid,
  output logic        txReady,
  output logic        txOe,
  input  logic        rxReady,
  output logic        rxValid,
  output logic        underrun,
  output logic        overrun,
  output fspStrobes_t stb
);

  localparam int CW = $clog2(W + 3);
  localparam logic [CW-1:0] LAST_OFS = CW'(W - 1);

  logic [1:0]    cfgEff;
  logic          txActive, txFull, txOeReg, txStart, txAccept;
  logic [1:0]    txDly;
  logic [CW-1:0] txCnt, txDlyW, txLast, txCntNext;
  logic          rxActive, rxStart;
  logic [1:0]    rxDly;
  logic [CW-1:0] rxCnt, rxDlyW, rxLast;

  assign cfgEff = effDelay(cfgDelay);

  // ---------------- transmit sequencing ----------------
  assign txStart   = !txActive && fsIn;
  assign txAccept  = txValid && !txFull;
  assign txReady   = !txFull;
  assign txDlyW    = CW'(txDly);
  assign txLast    = txDlyW + LAST_OFS;
  assign txCntNext = txCnt + CW'(1);

  always_comb begin
    stb            = '0;
    stb.holdWrite  = txAccept;
    stb.txLoad     = txStart;
    stb.txLoadSkip = (cfgEff == 2'd0);
    stb.txLoadZero = !txFull;
    stb.txShift    = txActive && (txCnt >= txDlyW);
    stb.lead       = !txActive && fsIn && (cfgEff == 2'd0);
    stb.leadFull   = txFull;
    stb.rxShift    = rxStart ? (cfgEff == 2'd0) : (rxActive && (rxCnt >= rxDlyW));
    stb.rxFinish   = rxActive && (rxCnt == rxLast);
  end

  assign txOe = txOeReg | stb.lead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0;
      txCnt    <= '0;
      txDly    <= 2'd0;
      txOeReg  <= 1'b0;
      txFull   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      txFull <= txAccept | (txFull & ~txStart);
      if (txStart) begin
        txActive <= 1'b1;
        txCnt    <= CW'(1);
        txDly    <= cfgEff;
        txOeReg  <= (cfgEff <= 2'd1);
        if (!txFull) underrun <= 1'b1;
      end else if (txActive) begin
        txCnt   <= txCntNext;
        txOeReg <= (txCntNext >= txDlyW) && (txCnt != txLast);
        if (txCnt == txLast) txActive <= 1'b0;
      end else begin
        txOeReg <= 1'b0;
      end
    end
  end

  // ---------------- receive sequencing ----------------
  assign rxStart = !rxActive && fsNeg;
  assign rxDlyW  = CW'(rxDly);
  assign rxLast  = rxDlyW + LAST_OFS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxCnt    <= '0;
      rxDly    <= 2'd0;
      rxValid  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (rxStart) begin
        rxActive <= 1'b1;
        rxCnt    <= CW'(1);
        rxDly    <= cfgEff;
      end else if (rxActive) begin
        rxCnt <= rxCnt + CW'(1);
        if (stb.rxFinish) rxActive <= 1'b0;
      end
      rxValid <= stb.rxFinish | (rxValid & ~rxReady);
      if (stb.rxFinish && rxValid && !rxReady) overrun <= 1'b1;
    end
  end

  // ---------------- assertions ----------------
  // R11
  tx_delay_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && !$past(txStart) && $past(txActive)) |-> $stable(txDly));

  // R6
  tx_oe_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    txOeReg |-> txActive);

  // R7
  tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txFull && !fsIn) |=> !txReady);

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> rxValid);

  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxValid && !rxReady));

endmodule

// File: rtl/fsp_datapath.sv
module fsp_datapath
  import fsp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  fspStrobes_t   stb,
  input  logic [W-1:0]  txWord,
  input  logic          txOe,
  input  logic          fsIn,
  input  logic          rxIn,
  output logic          fsNeg,
  output logic          txOut,
  output logic [W-1:0]  rxData
);

  logic [W-1:0] holdReg, txShiftReg, rxShiftReg;
  logic         rxSample, txBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg    <= '0;
      txShiftReg <= '0;
    end else begin
      if (stb.holdWrite) holdReg <= txWord;
      if (stb.txLoad) begin
        if (stb.txLoadZero)      txShiftReg <= '0;
        else if (stb.txLoadSkip) txShiftReg <= holdReg << 1;
        else                     txShiftReg <= holdReg;
      end else if (stb.txShift) begin
        txShiftReg <= txShiftReg << 1;
      end
    end
  end

  assign txBit = stb.lead ? (stb.leadFull & holdReg[W-1]) : txShiftReg[W-1];
  assign txOut = txOe & txBit;

  // falling-edge samplers for line and frame sync
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      fsNeg    <= 1'b0;
      rxSample <= 1'b0;
    end else begin
      fsNeg    <= fsIn;
      rxSample <= rxIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftReg <= '0;
      rxData     <= '0;
    end else begin
      if (stb.rxShift)  rxShiftReg <= {rxShiftReg[W-2:0], rxSample};
      if (stb.rxFinish) rxData     <= {rxShiftReg[W-2:0], rxSample};
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.leadFull |=> $stable(holdReg));

endmodule

// File: rtl/fsync_serial_port.sv
module fsync_serial_port
  import fsp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         fsIn,
  input  logic [1:0]   cfgDelay,
  input  logic         txValid,
  output logic         txReady,
  input  logic [W-1:0] txWord,
  output logic         txOut,
  output logic         txOe,
  input  logic         rxIn,
  output logic [W-1:0] rxData,
  output logic         rxValid,
  input  logic         rxReady,
  output logic         underrun,
  output logic         overrun
);

  fspStrobes_t stb;
  logic        fsNeg;

  fsp_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .fsIn(fsIn), .fsNeg(fsNeg), .cfgDelay(cfgDelay),
    .txValid(txValid), .txReady(txReady), .txOe(txOe), .rxReady(rxReady),
    .rxValid(rxValid), .underrun(underrun), .overrun(overrun), .stb(stb)
  );

  fsp_datapath #(.W(W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .txWord(txWord), .txOe(txOe),
    .fsIn(fsIn), .rxIn(rxIn), .fsNeg(fsNeg), .txOut(txOut), .rxData(rxData)
  );

endmodule

// File: tb/fsync_serial_port_bench.sv
`timescale 1ns/1ps
module fsync_serial_port_bench;
  localparam int W = 8;
  localparam int NV = 8;
  // {delay select, word}
  localparam logic [W+1:0] VECS [NV] = '{
    {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd2, 8'h81}, {2'd0, 8'hFF},
    {2'd1, 8'h01}, {2'd2, 8'h5A}, {2'd3, 8'hC3}, {2'd0, 8'h7E}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rstN, fsIn, txValid, txReady, txOut, txOe, rxIn, rxValid, rxReady;
  logic underrun, overrun;
  logic [1:0] cfgDelay;
  logic [W-1:0] txWord, rxData;

  assign rxIn = txOe ? txOut : 1'b1;  // undriven line reads high

  fsync_serial_port #(.W(W)) u_fsync_serial_port (
    .clk(clk), .rstN(rstN), .fsIn(fsIn), .cfgDelay(cfgDelay),
    .txValid(txValid), .txReady(txReady), .txWord(txWord), .txOut(txOut),
    .txOe(txOe), .rxIn(rxIn), .rxData(rxData), .rxValid(rxValid),
    .rxReady(rxReady), .underrun(underrun), .overrun(overrun)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pushWord(input logic [W-1:0] w);
    @(posedge clk); #1;
    chk(txReady == 1'b1, "R7", txReady, 1);
    txValid = 1'b1; txWord = w;
    @(posedge clk); #1;
    txValid = 1'b0;
    @(negedge clk);
    chk(txReady == 1'b0, "R7", txReady, 0);
  endtask

  // Runs one frame and probes the pin in every period (R1, R2, R3, R5, R6, R11)
  task automatic runFrame(input logic [1:0] sel, input logic [W-1:0] expWord);
    int d;
    bit expOe;
    string tag;
    d = (sel == 2'd3) ? 2 : int'(sel);
    @(posedge clk); #1;
    cfgDelay = sel; fsIn = 1'b1;
    for (int p = 0; p <= d + W + 1; p++) begin
      @(negedge clk);
      expOe = (p >= d) && (p < d + W);
      chk(txOe == expOe, "R6", txOe, expOe);
      if (expOe) begin
        tag = (p == 0) ? "R3" : ((d == 2) ? "R5" : "R1/R2");
        chk(txOut == expWord[W-1-(p-d)], tag, txOut, expWord[W-1-(p-d)]);
      end else begin
        chk(txOut == 1'b0, "R6", txOut, 0);
      end
      @(posedge clk); #1;
      if (p == 0) begin
        fsIn = 1'b0;
        cfgDelay = sel ^ 2'b01;  // R11: late change must not matter
      end
    end
    @(negedge clk);
    chk(txReady == 1'b1, "R7", txReady, 1);
  endtask

  task automatic takeWord();
    @(posedge clk); #1; rxReady = 1'b1;
    @(posedge clk); #1; rxReady = 1'b0;
    @(negedge clk);
    chk(rxValid == 1'b0, "R9", rxValid, 0);
  endtask

  initial begin
    rstN = 1'b0; fsIn = 1'b0; cfgDelay = 2'd1; txValid = 1'b0; txWord = '0; rxReady = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R12
    chk(txOe == 1'b0, "R12", txOe, 0);
    chk(txReady == 1'b1, "R12", txReady, 1);
    chk(rxValid == 1'b0, "R12", rxValid, 0);
    chk(underrun == 1'b0, "R12", underrun, 0);
    chk(overrun == 1'b0, "R12", overrun, 0);

    for (int i = 0; i < NV; i++) begin
      pushWord(VECS[i][W-1:0]);
      runFrame(VECS[i][W+1:W], VECS[i][W-1:0]);
      // R4 (word assembled; with two-bit delay the framing ones are skipped, R5)
      chk(rxValid == 1'b1, "R4", rxValid, 1);
      chk(rxData == VECS[i][W-1:0], (VECS[i][W+1:W] >= 2) ? "R5" : "R4", rxData, VECS[i][W-1:0]);
      repeat (2) @(negedge clk);
      chk(rxValid == 1'b1, "R9", rxValid, 1);
      takeWord();
    end
    chk(underrun == 1'b0, "R8", underrun, 0);

    // R8: frame with no word held
    runFrame(2'd1, 8'h00);
    chk(underrun == 1'b1, "R8", underrun, 1);
    chk(rxData == 8'h00, "R8", rxData, 0);
    takeWord();

    // R10: second word lands on an untaken one
    pushWord(8'h96);
    runFrame(2'd1, 8'h96);
    chk(overrun == 1'b0, "R10", overrun, 0);
    pushWord(8'h4B);
    runFrame(2'd0, 8'h4B);
    chk(overrun == 1'b1, "R10", overrun, 1);
    chk(rxValid == 1'b1, "R10", rxValid, 1);
    chk(rxData == 8'h4B, "R10", rxData, 8'h4B);
    chk(underrun == 1'b1, "R8", underrun, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule